// File: doc/BRIEF.md
# Auto-Reload 8-Bit Timer/Counter

This block is an 8-bit up-counter with a reload buffer that software can write at any time. When the count steps past 0xFF, the counter takes the buffered reload value instead of wrapping to zero, and a sticky overflow flag is raised. A new period can therefore be queued without disturbing the count in progress. The reload is always active while the timer runs. No control bit is needed to arm it.

The counter advances on one of three single-cycle strobes, all in the system clock domain:

- an instruction-cycle tick, divided by a power-of-two prescaler of 1 to 128;
- a fast oscillator tick, used undivided;
- an external event pin, synchronised through two flops, where each rising edge counts once.

A small write port sets the control word, the counter and the reload buffer. The counter value and the flag are visible at the outputs. The interrupt request is the flag gated by an interrupt-enable bit.

The control logic is a two-state machine:

- **STOP**: the timer is disabled and the counter holds its value.
- **COUNT**: the counter advances on each selected tick.
- Transition **START** (STOP to COUNT) happens on a control write with the enable bit set.
- Transition **HALT** (COUNT to STOP) happens on a control write with the enable bit clear.

Top module: `reload_timer8`

## Requirements
- R1: In STOP the counter holds its value. In COUNT it increments by one on each cycle where the selected tick is present. Control write (address 0) fields: bit 0 enable, bit 1 fast source, bit 2 external source, bits 5:3 rate, bit 6 interrupt enable. A control write takes effect from the next cycle.
- R2: A tick while the counter is 0xFF is an overflow. The counter loads the reload buffer and the flag becomes 1 on the same edge.
- R3: The flag stays 1 until a cycle with `flag_clr` high and no overflow. If a clear and an overflow occur in the same cycle, the flag remains 1.
- R4: A write to the reload buffer (address 2) leaves the counter unchanged. Only the next overflow uses the new value.
- R5: With the external-source bit set, the tick is a rising edge of `evt_pin`. It is counted on the third clock edge after the pin is sampled high. The fast bit, the rate and the other strobes are ignored.
- R6: With the external-source bit clear and the fast bit set, every `tick_fast` strobe counts and the rate field is ignored.
- R7: With both source bits clear, `tick_cpu` strobes are divided by 2^(7-rate): rate 0 gives /128 and rate 7 gives /1. The first divided tick falls on the 2^(7-rate)-th strobe.
- R8: The prescaler restarts from zero in STOP and in the first cycle after the rate field changes. A strobe in that cycle is not counted.
- R9: `irq` is 1 exactly when the flag is 1 and the interrupt-enable bit is 1.
- R10: A counter write (address 1) loads the counter on that edge, takes priority over counting and overflow, and leaves the reload buffer unchanged. Writes to address 3 have no effect.
- R11: After reset the counter, the reload buffer, the flag and `irq` are 0, the state is STOP and the rate field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_cpu | input | 1 | Instruction-cycle strobe |
| tick_fast | input | 1 | Fast oscillator strobe |
| evt_pin | input | 1 | Asynchronous external event pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 counter, 2 reload |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clear the overflow flag |
| cnt_value | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an overflow landing in the same cycle as a flag clear. Random source strobes rarely line up with a clear pulse, so the stimulus silences all sources and writes 0xFF into the counter. It then raises a single fast strobe together with `flag_clr`, which fixes the collision to one known edge. The prescaler restart after a rate change is the other subtle case. It is reached by rewriting the rate in the middle of a divided period while instruction ticks arrive every cycle. A behavioural model follows every edge, so a lost or extra divided tick appears as a counter mismatch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        ST_STOP  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_FAST = 2'd1,
        SRC_EXT  = 2'd2
    } tmr_src_e;

    typedef logic [1:0] tmr_addr_t;

    localparam tmr_addr_t ADDR_CTRL   = 2'd0;
    localparam tmr_addr_t ADDR_CNT    = 2'd1;
    localparam tmr_addr_t ADDR_RELOAD = 2'd2;

    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_FAST_BIT = 1;
    localparam int unsigned CTL_EXT_BIT  = 2;
    localparam int unsigned CTL_RATE_LSB = 3;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_in,
    input  logic [RATE_W-1:0] rate,
    output logic              tick_out
);
    localparam int unsigned PRE_W = (1 << RATE_W) - 1;

    logic [PRE_W-1:0]  pre_q;
    logic [RATE_W-1:0] rate_q;
    logic [PRE_W:0]    span;
    logic [PRE_W-1:0]  term;
    logic              restart;

    // divisor 2^(max-rate): the shift amount is the inverted rate
    always_comb begin
        span    = (PRE_W+1)'(1) << (~rate);
        term    = PRE_W'(span - 1'b1);
        restart = !run || (rate != rate_q);
        tick_out = tick_in && !restart && (pre_q == term);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            rate_q <= '0;
        end else begin
            rate_q <= rate;
            if (restart) begin
                pre_q <= '0;
            end else if (tick_in) begin
                pre_q <= (pre_q == term) ? '0 : pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_pkg::*;
#(
    parameter int unsigned RATE_W = 3,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  tmr_src_e          src,
    input  logic [RATE_W-1:0] rate,
    input  logic              tick_cpu,
    input  logic              tick_fast,
    input  logic              evt_pin,
    output logic              cnt_tick
);
    logic [SYNC_N:0] sync_q;
    logic            ext_edge;
    logic            cpu_div;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-1:0], evt_pin};
    end

    assign ext_edge = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

    generate
        if (RATE_W > 0) begin : g_pre
            tmr_prescale #(.RATE_W(RATE_W)) u_pre (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (run),
                .tick_in  (tick_cpu),
                .rate     (rate),
                .tick_out (cpu_div)
            );
        end else begin : g_nopre
            assign cpu_div = tick_cpu;
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_EXT:  cnt_tick = ext_edge;
            SRC_FAST: cnt_tick = tick_fast;
            default:  cnt_tick = cpu_div;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tmr_addr_t         wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              flag_clr,
    input  logic              cnt_tick,
    output logic              run,
    output tmr_src_e          src,
    output logic [RATE_W-1:0] rate,
    output logic              irq_en,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              flag_q
);
    localparam int unsigned IE_BIT = CTL_RATE_LSB + RATE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             flag_d;
    logic             wrap;
    logic             wr_ctrl, wr_cnt, wr_rel;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_cnt  = wr_en && (wr_addr == ADDR_CNT);
    assign wr_rel  = wr_en && (wr_addr == ADDR_RELOAD);

    // next state: START / HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (wr_ctrl &&  wr_data[CTL_EN_BIT]) state_d = ST_COUNT;
            ST_COUNT: if (wr_ctrl && !wr_data[CTL_EN_BIT]) state_d = ST_STOP;
            default:  state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // outputs: counter and flag update
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                if (wr_cnt) cnt_d = wr_data;
            end
            ST_COUNT: begin
                if (wr_cnt) begin
                    cnt_d = wr_data;
                end else if (cnt_tick) begin
                    if (cnt_q == CNT_MAX) begin
                        cnt_d = reload_q;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: cnt_d = cnt_q;
        endcase
        if (wrap)          flag_d = 1'b1;
        else if (flag_clr) flag_d = 1'b0;
        else               flag_d = flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            flag_q   <= 1'b0;
            reload_q <= '0;
            src      <= SRC_CPU;
            rate     <= '0;
            irq_en   <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
            if (wr_rel) reload_q <= wr_data;
            if (wr_ctrl) begin
                rate   <= wr_data[CTL_RATE_LSB +: RATE_W];
                irq_en <= wr_data[IE_BIT];
                if (wr_data[CTL_EXT_BIT])       src <= SRC_EXT;
                else if (wr_data[CTL_FAST_BIT]) src <= SRC_FAST;
                else                            src <= SRC_CPU;
            end
        end
    end

    assign run = (state_q == ST_COUNT);
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned RATE_W = 3,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_cpu,
    input  logic             tick_fast,
    input  logic             evt_pin,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_value,
    output logic             ovf_flag,
    output logic             irq
);
    logic              run_en;
    tmr_src_e          src_sel;
    logic [RATE_W-1:0] rate_sel;
    logic              irq_en;
    logic              cnt_tick;
    logic [CNT_W-1:0]  reload_q;

    tmr_src_sel #(.RATE_W(RATE_W), .SYNC_N(SYNC_N)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_en),
        .src       (src_sel),
        .rate      (rate_sel),
        .tick_cpu  (tick_cpu),
        .tick_fast (tick_fast),
        .evt_pin   (evt_pin),
        .cnt_tick  (cnt_tick)
    );

    tmr_core #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .cnt_tick (cnt_tick),
        .run      (run_en),
        .src      (src_sel),
        .rate     (rate_sel),
        .irq_en   (irq_en),
        .cnt_q    (cnt_value),
        .reload_q (reload_q),
        .flag_q   (ovf_flag)
    );

    assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/reload_timer8_chk.sv
module reload_timer8_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             cnt_tick,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             flag_clr,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] cnt_value,
    input logic             ovf_flag
);
    logic wr_cnt;
    assign wr_cnt = wr_en && (wr_addr == 2'd1);

    a_r1_hold_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_cnt) |=> $stable(cnt_value));

    a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_tick && !wr_cnt && cnt_value != '1)
        |=> cnt_value == $past(cnt_value) + 1'b1);

    a_r2_wrap_loads_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_tick && !wr_cnt && cnt_value == '1)
        |=> (cnt_value == $past(reload_q)) && ovf_flag);

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    a_r3_flag_rises_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(run_en && cnt_tick && cnt_value == '1));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_value == $past(wr_data));
endmodule

bind reload_timer8 reload_timer8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cnt_tick  (cnt_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flag_clr  (flag_clr),
    .reload_q  (reload_q),
    .cnt_value (cnt_value),
    .ovf_flag  (ovf_flag)
);

// File: tb/reload_timer8_tb.sv
`timescale 1ns/1ps
module reload_timer8_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_cpu = 1'b0, tick_fast = 1'b0, evt_pin = 1'b0;
    logic       wr_en = 1'b0, flag_clr = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_value;
    logic       ovf_flag, irq;

    always #2.5 clk = ~clk;

    reload_timer8 u_dut (
        .clk(clk), .rst_n(rst_n), .tick_cpu(tick_cpu), .tick_fast(tick_fast),
        .evt_pin(evt_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_clr(flag_clr), .cnt_value(cnt_value), .ovf_flag(ovf_flag), .irq(irq)
    );

    int    n_chk = 0, n_bad = 0;
    string phase = "R11";
    bit    done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_rel, m_flag, m_en, m_fast, m_ext, m_rate, m_prev_rate, m_ie, m_pc;
    int h0, h1, h2;
    always @(posedge clk) begin
        int tick, ptick, ovf, edge_seen, div;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_flag = 0; m_en = 0; m_fast = 0; m_ext = 0;
            m_rate = 0; m_prev_rate = 0; m_ie = 0; m_pc = 0; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            edge_seen = (h1 == 1 && h2 == 0) ? 1 : 0;
            div = 1 << (7 - m_rate);
            ptick = 0;
            if (m_en == 0 || m_rate != m_prev_rate) m_pc = 0;
            else if (tick_cpu) begin
                m_pc = m_pc + 1;
                if (m_pc == div) begin ptick = 1; m_pc = 0; end
            end
            tick = m_ext ? edge_seen : (m_fast ? int'(tick_fast) : ptick);
            m_prev_rate = m_rate;
            h2 = h1; h1 = h0; h0 = int'(evt_pin);
            ovf = 0;
            if (wr_en && wr_addr == 2'd1) m_cnt = wr_data;
            else if (m_en != 0 && tick != 0) begin
                if (m_cnt == 255) begin m_cnt = m_rel; ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (ovf != 0) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (wr_en && wr_addr == 2'd2) m_rel = wr_data;
            if (wr_en && wr_addr == 2'd0) begin
                m_en = wr_data[0]; m_fast = wr_data[1]; m_ext = wr_data[2];
                m_rate = int'(wr_data[5:3]); m_ie = wr_data[6];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({phase, " counter"}, cnt_value, m_cnt);
            chk({phase, " flag"}, ovf_flag, m_flag);
            chk("R9 irq", irq, (m_flag != 0 && m_ie != 0) ? 1 : 0);
        end
    end

    int lfsr = 32'h1ace;
    function automatic bit rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        return lfsr[0];
    endfunction

    // cpu/fast modes: 0 off, 1 always, 2 random; pin_per: pin half-period (0 = hold low)
    int cpu_m = 0, fast_m = 0, pin_per = 0, pin_ct = 0;
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            tick_cpu  = (cpu_m == 1) || (cpu_m == 2 && rnd());
            tick_fast = (fast_m == 1) || (fast_m == 2 && rnd());
            if (pin_per > 0) begin
                pin_ct++;
                if (pin_ct >= pin_per) begin pin_ct = 0; evt_pin = ~evt_pin; end
            end
            @(negedge clk);
        end
        tick_cpu = 0; tick_fast = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        phase = "R11";
        chk("R11 reset counter", cnt_value, 0);
        chk("R11 reset flag", ovf_flag, 0);
        chk("R11 reset irq", irq, 0);

        // R1: stopped counter holds under ticks
        phase = "R1"; cpu_m = 1; fast_m = 1;
        run(20);
        chk("R1 hold in STOP", cnt_value, 0);

        // R10: counter write, address 3 ignored
        phase = "R10";
        wr(2'd1, 8'hF8);
        chk("R10 counter write", cnt_value, 8'hF8);
        wr(2'd3, 8'h55);
        chk("R10 address 3 ignored", cnt_value, 8'hF8);

        // R6: fast source, every strobe counts
        phase = "R6";
        wr(2'd2, 8'h10);
        wr(2'd0, 8'h03 | (8'd2 << 3));
        fast_m = 1; cpu_m = 0;
        run(5);
        chk("R6 fast counts undivided", cnt_value, 8'hFD);

        // R2/R4: overflow loads reload written mid-count
        phase = "R4";
        fast_m = 0;
        wr(2'd2, 8'h37);
        chk("R4 reload write keeps counter", cnt_value, 8'hFD);
        fast_m = 1;
        run(3);
        chk("R2 overflow loads reload", cnt_value, 8'h37);
        chk("R2 overflow sets flag", ovf_flag, 1);
        fast_m = 2;
        run(400);

        // R3: clear coinciding with overflow
        phase = "R3";
        fast_m = 0;
        wr(2'd1, 8'hFF);
        tick_fast = 1; flag_clr = 1;
        @(negedge clk);
        tick_fast = 0; flag_clr = 0;
        chk("R3 overflow beats clear", ovf_flag, 1);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        chk("R3 clear drops flag", ovf_flag, 0);

        // R9: interrupt gating
        phase = "R9";
        wr(2'd1, 8'hFE);
        fast_m = 1;
        run(2);
        chk("R9 irq masked", irq, 0);
        wr(2'd0, 8'h43);
        chk("R9 irq enabled", irq, 1);
        flag_clr = 1; @(negedge clk); flag_clr = 0;

        // R7: each prescaler rate with cpu strobes
        phase = "R7";
        fast_m = 1;
        for (int r = 0; r < 8; r++) begin
            wr(2'd0, 8'h01 | 8'(r << 3));
            cpu_m = (r % 2 == 0) ? 1 : 2;
            run(300);
        end
        wr(2'd0, 8'h01 | (8'd7 << 3));
        wr(2'd1, 8'h00);
        cpu_m = 1; run(10);
        chk("R7 rate 7 divides by 1", cnt_value, 10);

        // R8: rate change mid-period and restart after STOP
        phase = "R8";
        wr(2'd0, 8'h01 | (8'd4 << 3));
        cpu_m = 1; run(5);
        wr(2'd0, 8'h01 | (8'd5 << 3));
        run(40);
        wr(2'd0, 8'h00 | (8'd5 << 3));
        run(3);
        wr(2'd0, 8'h01 | (8'd5 << 3));
        run(30);
        wr(2'd0, 8'h01 | (8'd3 << 3));
        run(64);
        cpu_m = 0;

        // R5: external pin, other strobes ignored
        phase = "R5";
        wr(2'd0, 8'h07 | (8'd7 << 3));
        wr(2'd1, 8'h00);
        cpu_m = 1; fast_m = 1; pin_per = 3;
        run(60);
        pin_per = 0; cpu_m = 0; fast_m = 0;
        run(4);
        chk("R5 ten pin edges counted", cnt_value, 10);
        wr(2'd1, 8'hFC);
        pin_per = 1; run(40); pin_per = 0; run(4);

        // R1: halt freezes count
        phase = "R1";
        wr(2'd0, 8'h02);
        snap = cnt_value;
        fast_m = 1; run(20); fast_m = 0;
        chk("R1 HALT freezes counter", cnt_value, snap);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule